// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block buffers 9-bit words between two unrelated clock domains. A producer pushes words on the write clock and a consumer pops them on the read clock. Four active-low status outputs report the fill state. Two of them are fixed: empty, which lives in the read domain, and full, which lives in the write domain. The other two carry user-set thresholds: almost-empty, which lives in the read domain, and almost-full, which lives in the write domain.

The shared select input `wr_sel` is sampled on clock edges while reset is held, and its level fixes the block's personality until the next reset:
- **Dual-enable personality** (`wr_sel` high during reset): `wr_sel` acts as a second, active-high write enable.
- **Offset-access personality** (`wr_sel` low during reset): holding `wr_sel` low steers accesses to the two threshold registers instead of the queue. Write-side strobes store a threshold, and read-side strobes return one on the output bus.

The output enable is modelled as a drive indication. The output bus is forced to zero while it is not driven.

Top module: `dc_flag_fifo`

## Requirements
- R1: A word on `wr_data` is queued at a rising `wclk` edge only when `wr_en_a_n` is 0, `wr_sel` is 1 and `full_n` is 1. This holds in both personalities.
- R2: A rising `rclk` edge pops the oldest word into the registered `rd_data` only when `rd_en_a_n` and `rd_en_b_n` are both 0 and `empty_n` is 1. If only one read enable is low, nothing is popped and `rd_data` holds. Words leave in the order they were queued.
- R3: The personality is taken from `wr_sel` on clock edges during reset. In the dual-enable personality, a write strobe with `wr_sel` at 0 queues nothing.
- R4: In the offset-access personality, a `wclk` edge with `wr_en_a_n`=0 and `wr_sel`=0 stores `wr_data` into a threshold register. Successive stores alternate: the empty threshold first, then the full threshold, then back to the empty threshold.
- R5: In the offset-access personality, an `rclk` edge with both read enables at 0 and `wr_sel`=0 loads the next threshold into `rd_data`. This follows the same empty-then-full alternation as R4, with its own position counter. It works whatever the fill level, and the queue contents and flags are left untouched.
- R6: `empty_n` is 0 exactly when the read domain's view of the fill level is zero.
- R7: `full_n` is 0 exactly when the write domain's view of the fill level equals DEPTH.
- R8: `almost_empty_n` is 0 when the read-side fill level is less than or equal to the empty threshold. `almost_full_n` is 0 when the write-side free space (DEPTH minus fill) is less than or equal to the full threshold. Thresholds are 9-bit unsigned values.
- R9: A write attempted while full and a read attempted while empty are both dropped. Storage and order are unchanged, and `rd_data` keeps its last value.
- R10: Reset empties the queue and clears `rd_data` to 0. It sets both thresholds to 7 and both alternation positions to the empty threshold. After reset, `empty_n`=0, `almost_empty_n`=0, `full_n`=1 and `almost_full_n`=1.
- R11: With `out_en_n`=0, `drive_en` is 1 and `rd_data` shows the output register. With `out_en_n`=1, `drive_en` is 0 and `rd_data` reads 0.
- R12: A write becomes visible to the read-side flags at the second `rclk` edge after the writing `wclk` edge. A pop becomes visible to the write-side flags at the second `wclk` edge after the popping `rclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_data | input | 9 | Word to queue, or threshold value in offset access |
| wr_en_a_n | input | 1 | Active-low primary write strobe |
| wr_sel | input | 1 | Shared select: second write enable, or active-low offset steering |
| rd_en_a_n | input | 1 | Active-low read strobe, first of two |
| rd_en_b_n | input | 1 | Active-low read strobe, second of two |
| out_en_n | input | 1 | Active-low output drive control |
| rd_data | output | 9 | Registered output word, zero when not driven |
| drive_en | output | 1 | High when `rd_data` is being driven |
| empty_n | output | 1 | Active-low empty flag, read domain |
| full_n | output | 1 | Active-low full flag, write domain |
| almost_empty_n | output | 1 | Active-low threshold flag, read domain |
| almost_full_n | output | 1 | Active-low threshold flag, write domain |

## Verification
The two pointers drive every flag, so a wrong pointer or a wrong synchronizer stage shows up as a flag that rises or falls on the wrong edge. The bench follows each crossing edge by edge and flags such an error within one clock of the domain that owns the flag. A dropped, duplicated or misrouted word shows up as a mismatch on `rd_data` at the very pop that returns it. A wrong alternation position or a wrong personality latch shows up at the next threshold read-back, or as a threshold flag that switches at the wrong fill level.

// File: rtl/dcff_pkg.sv
package dcff_pkg;

    localparam int DATA_W     = 9;
    localparam int OFS_RESET  = 7;
    localparam int GRAY_MAX_W = 16;

    typedef logic [DATA_W-1:0] word_t;

    // which threshold register the next offset access targets
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } ofs_slot_e;

    function automatic logic [GRAY_MAX_W-1:0] bin_to_gray(input logic [GRAY_MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GRAY_MAX_W-1:0] gray_to_bin(input logic [GRAY_MAX_W-1:0] g);
        logic [GRAY_MAX_W-1:0] b;
        b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
        for (int i = GRAY_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic ofs_slot_e next_slot(input ofs_slot_e s);
        return (s == SLOT_EMPTY) ? SLOT_FULL : SLOT_EMPTY;
    endfunction

endpackage

// File: rtl/dcff_gray_sync.sv
module dcff_gray_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_gray,
    output logic [W-1:0] dst_gray
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = src_gray;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dst_gray = st_q.stable;

endmodule

// File: rtl/dcff_mem.sv
module dcff_mem import dcff_pkg::*; #(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    word_t cells_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];

endmodule

// File: rtl/dcff_wr_ctrl.sv
module dcff_wr_ctrl import dcff_pkg::*; #(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int CW    = (PW > DATA_W) ? PW : DATA_W
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en_a_n,
    input  logic          wr_sel,
    input  word_t         wr_data,
    input  logic [PW-1:0] rgray_sync,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [PW-1:0] wgray,
    output word_t         ofs_empty,
    output word_t         ofs_full,
    output logic          full_n,
    output logic          almost_full_n
);

    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wbin;
        logic [PW-1:0] wgray;
        word_t         thr_empty;
        word_t         thr_full;
        ofs_slot_e     slot;
    } wr_st_t;

    wr_st_t st_d, st_q;
    logic   load_mode_q;

    logic [PW-1:0] rbin;
    logic [PW-1:0] level;
    logic [PW-1:0] room;
    logic          is_full;
    logic          near_full;
    logic          ofs_wr;
    logic          dat_wr;

    always_comb begin
        rbin      = PW'(gray_to_bin(GRAY_MAX_W'(rgray_sync)));
        level     = st_q.wbin - rbin;
        room      = FULL_LVL - level;
        is_full   = (level == FULL_LVL);
        near_full = (CW'(room) <= CW'(st_q.thr_full));
        ofs_wr    = load_mode_q & ~wr_en_a_n & ~wr_sel;
        dat_wr    = ~wr_en_a_n & wr_sel & ~is_full;

        st_d = st_q;
        if (ofs_wr) begin
            if (st_q.slot == SLOT_FULL) begin
                st_d.thr_full = wr_data;
            end else begin
                st_d.thr_empty = wr_data;
            end
            st_d.slot = next_slot(st_q.slot);
        end
        if (dat_wr) begin
            st_d.wbin = st_q.wbin + PW'(1);
        end
        st_d.wgray = PW'(bin_to_gray(GRAY_MAX_W'(st_d.wbin)));
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wbin: '0, wgray: '0,
                      thr_empty: DATA_W'(OFS_RESET), thr_full: DATA_W'(OFS_RESET),
                      slot: SLOT_EMPTY};
        end else begin
            st_q <= st_d;
        end
    end

    // personality latch: follows wr_sel only while reset is held
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            load_mode_q <= ~wr_sel;
        end
    end

    assign mem_we        = dat_wr;
    assign mem_waddr     = st_q.wbin[AW-1:0];
    assign wgray         = st_q.wgray;
    assign ofs_empty     = st_q.thr_empty;
    assign ofs_full      = st_q.thr_full;
    assign full_n        = ~is_full;
    assign almost_full_n = ~near_full;

    // R7
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        level <= FULL_LVL);

    // R9
    full_write_dropped_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (is_full && !wr_en_a_n && wr_sel) |=> $stable(st_q.wbin));

    // R3
    mode_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(load_mode_q));

    // R12
    wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(st_q.wgray ^ $past(st_q.wgray)) <= 1);

endmodule

// File: rtl/dcff_rd_ctrl.sv
module dcff_rd_ctrl import dcff_pkg::*; #(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int CW    = (PW > DATA_W) ? PW : DATA_W
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_en_a_n,
    input  logic          rd_en_b_n,
    input  logic          wr_sel,
    input  logic [PW-1:0] wgray_sync,
    input  word_t         mem_rdata,
    input  word_t         ofs_empty,
    input  word_t         ofs_full,
    output logic [AW-1:0] mem_raddr,
    output logic [PW-1:0] rgray,
    output word_t         out_word,
    output logic          empty_n,
    output logic          almost_empty_n
);

    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] rbin;
        logic [PW-1:0] rgray;
        word_t         word;
        ofs_slot_e     slot;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic   load_mode_q;

    logic [PW-1:0] wbin;
    logic [PW-1:0] level;
    logic          is_empty;
    logic          near_empty;
    logic          rd_req;
    logic          ofs_rd;
    logic          dat_rd;

    always_comb begin
        wbin       = PW'(gray_to_bin(GRAY_MAX_W'(wgray_sync)));
        level      = wbin - st_q.rbin;
        is_empty   = (level == '0);
        near_empty = (CW'(level) <= CW'(ofs_empty));
        rd_req     = ~rd_en_a_n & ~rd_en_b_n;
        ofs_rd     = rd_req & load_mode_q & ~wr_sel;
        dat_rd     = rd_req & ~ofs_rd & ~is_empty;

        st_d = st_q;
        if (ofs_rd) begin
            st_d.word = (st_q.slot == SLOT_FULL) ? ofs_full : ofs_empty;
            st_d.slot = next_slot(st_q.slot);
        end else if (dat_rd) begin
            st_d.word = mem_rdata;
            st_d.rbin = st_q.rbin + PW'(1);
        end
        st_d.rgray = PW'(bin_to_gray(GRAY_MAX_W'(st_d.rbin)));
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rbin: '0, rgray: '0, word: '0, slot: SLOT_EMPTY};
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            load_mode_q <= ~wr_sel;
        end
    end

    assign mem_raddr      = st_q.rbin[AW-1:0];
    assign rgray          = st_q.rgray;
    assign out_word       = st_q.word;
    assign empty_n        = ~is_empty;
    assign almost_empty_n = ~near_empty;

    // R6
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        level <= FULL_LVL);

    // R9
    empty_read_dropped_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (is_empty && rd_req && !ofs_rd) |=> ($stable(st_q.rbin) && $stable(st_q.word)));

    // R5
    ofs_read_keeps_ptr_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        ofs_rd |=> $stable(st_q.rbin));

    // R12
    rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(st_q.rgray ^ $past(st_q.rgray)) <= 1);

endmodule

// File: rtl/dc_flag_fifo.sv
module dc_flag_fifo import dcff_pkg::*; #(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en_a_n,
    input  logic              wr_sel,
    input  logic              rd_en_a_n,
    input  logic              rd_en_b_n,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              drive_en,
    output logic              empty_n,
    output logic              full_n,
    output logic              almost_empty_n,
    output logic              almost_full_n
);

    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [AW-1:0] mem_raddr;
    word_t         mem_rdata;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wgray_in_rd;
    logic [PW-1:0] rgray_in_wr;
    word_t         ofs_empty;
    word_t         ofs_full;
    word_t         out_word;

    dcff_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .wclk          (wclk),
        .rst_n         (rst_n),
        .wr_en_a_n     (wr_en_a_n),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .rgray_sync    (rgray_in_wr),
        .mem_we        (mem_we),
        .mem_waddr     (mem_waddr),
        .wgray         (wgray),
        .ofs_empty     (ofs_empty),
        .ofs_full      (ofs_full),
        .full_n        (full_n),
        .almost_full_n (almost_full_n)
    );

    dcff_gray_sync #(.W(PW)) u_w2r (
        .clk      (rclk),
        .rst_n    (rst_n),
        .src_gray (wgray),
        .dst_gray (wgray_in_rd)
    );

    dcff_gray_sync #(.W(PW)) u_r2w (
        .clk      (wclk),
        .rst_n    (rst_n),
        .src_gray (rgray),
        .dst_gray (rgray_in_wr)
    );

    dcff_mem #(.DEPTH(DEPTH)) u_mem (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    dcff_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .rclk           (rclk),
        .rst_n          (rst_n),
        .rd_en_a_n      (rd_en_a_n),
        .rd_en_b_n      (rd_en_b_n),
        .wr_sel         (wr_sel),
        .wgray_sync     (wgray_in_rd),
        .mem_rdata      (mem_rdata),
        .ofs_empty      (ofs_empty),
        .ofs_full       (ofs_full),
        .mem_raddr      (mem_raddr),
        .rgray          (rgray),
        .out_word       (out_word),
        .empty_n        (empty_n),
        .almost_empty_n (almost_empty_n)
    );

    assign drive_en = ~out_en_n;
    assign rd_data  = out_en_n ? '0 : out_word;

    // R11
    undriven_bus_zero_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !drive_en |-> (rd_data == '0));

endmodule

// File: tb/dc_flag_fifo_bench.sv
module dc_flag_fifo_bench;

    localparam int DEPTH     = 64;
    localparam int WCLK_HALF = 5;    // write period 10
    localparam int RCLK_HALF = 7;    // read period 14, edges offset so they never meet
    localparam int WATCHDOG  = 150000;

    logic       wclk, rclk, rst_n;
    logic [8:0] wr_data;
    logic       wr_en_a_n, wr_sel, rd_en_a_n, rd_en_b_n, out_en_n;
    logic [8:0] rd_data;
    logic       drive_en, empty_n, full_n, almost_empty_n, almost_full_n;

    int errors = 0;
    int checks = 0;

    dc_flag_fifo #(.DEPTH(DEPTH)) u_dc_flag_fifo (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .wr_data(wr_data), .wr_en_a_n(wr_en_a_n), .wr_sel(wr_sel),
        .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .out_en_n(out_en_n),
        .rd_data(rd_data), .drive_en(drive_en), .empty_n(empty_n), .full_n(full_n),
        .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
    );

    initial begin
        wclk = 1'b0;
        #WCLK_HALF wclk = 1'b1;
        forever #WCLK_HALF wclk = ~wclk;
    end

    initial begin
        rclk = 1'b0;
        #2 rclk = 1'b1;
        forever #RCLK_HALF rclk = ~rclk;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int         m_wptr, m_rptr, m_ws1, m_ws2, m_rs1, m_rs2;
    int         m_thr[2];
    int         m_wslot, m_rslot;
    bit         m_load_w, m_load_r;
    int         m_word;
    logic [8:0] m_q[$];

    always @(posedge wclk) begin
        if (!rst_n) begin
            m_load_w = !wr_sel;
            m_wptr = 0; m_rs1 = 0; m_rs2 = 0;
            m_thr[0] = 7; m_thr[1] = 7; m_wslot = 0;
            m_q.delete();
        end else begin
            int full;
            full = ((m_wptr - m_rs2) == DEPTH);
            if (!wr_en_a_n) begin
                if (m_load_w && !wr_sel) begin
                    m_thr[m_wslot] = int'(wr_data);
                    m_wslot ^= 1;
                end else if (wr_sel && !full) begin
                    m_q.push_back(wr_data);
                    m_wptr++;
                end
            end
            m_rs2 = m_rs1;
            m_rs1 = m_rptr;
        end
        #2;
        if (rst_n) begin
            chk("R7 R12 full_n", int'(full_n), ((m_wptr - m_rs2) == DEPTH) ? 0 : 1);
            chk("R8 almost_full_n", int'(almost_full_n),
                ((DEPTH - (m_wptr - m_rs2)) <= m_thr[1]) ? 0 : 1);
        end
    end

    always @(posedge rclk) begin
        if (!rst_n) begin
            m_load_r = !wr_sel;
            m_rptr = 0; m_ws1 = 0; m_ws2 = 0; m_rslot = 0; m_word = 0;
        end else begin
            int lvl;
            lvl = m_ws2 - m_rptr;
            if (!rd_en_a_n && !rd_en_b_n) begin
                if (m_load_r && !wr_sel) begin
                    m_word = m_thr[m_rslot];
                    m_rslot ^= 1;
                end else if (lvl != 0) begin
                    m_word = int'(m_q.pop_front());
                    m_rptr++;
                end
            end
            m_ws2 = m_ws1;
            m_ws1 = m_wptr;
        end
        #2;
        if (rst_n) begin
            chk("R6 R12 empty_n", int'(empty_n), ((m_ws2 - m_rptr) == 0) ? 0 : 1);
            chk("R8 almost_empty_n", int'(almost_empty_n),
                ((m_ws2 - m_rptr) <= m_thr[0]) ? 0 : 1);
            chk("R11 drive_en", int'(drive_en), out_en_n ? 0 : 1);
            chk("R1 R2 R5 R9 rd_data", int'(rd_data), out_en_n ? 0 : m_word);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wcyc(input logic a_n, input logic sel, input logic [8:0] d);
        @(posedge wclk); #2;
        wr_en_a_n = a_n; wr_sel = sel; wr_data = d;
    endtask

    task automatic rcyc(input logic a_n, input logic b_n, input logic oe_n);
        @(posedge rclk); #1;
        rd_en_a_n = a_n; rd_en_b_n = b_n; out_en_n = oe_n;
    endtask

    task automatic do_reset(input logic sel);
        @(posedge wclk); #4;
        rst_n = 1'b0; wr_sel = sel; wr_en_a_n = 1'b1;
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
        repeat (6) @(posedge wclk);
        #4 rst_n = 1'b1;
    endtask

    task automatic at_r();
        @(posedge rclk); #4;
    endtask

    task automatic at_w();
        @(posedge wclk); #4;
    endtask

    initial begin
        #WATCHDOG;
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_sel = 1'b1; wr_en_a_n = 1'b1; wr_data = '0;
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; out_en_n = 1'b0;
        repeat (6) @(posedge wclk);
        #4 rst_n = 1'b1;

        // R10 reset state
        at_r();
        chk("R10 empty_n", int'(empty_n), 0);
        chk("R10 almost_empty_n", int'(almost_empty_n), 0);
        chk("R10 rd_data", int'(rd_data), 0);
        at_w();
        chk("R10 full_n", int'(full_n), 1);
        chk("R10 almost_full_n", int'(almost_full_n), 1);

        // R3: dual-enable personality, second enable low blocks writes
        for (int i = 0; i < 3; i++) wcyc(1'b0, 1'b0, 9'h055);
        wcyc(1'b1, 1'b1, '0);
        repeat (4) at_r();
        chk("R3 empty_n after blocked writes", int'(empty_n), 0);

        // R1 R2: ten words, then reads with one enable held high, then full reads
        for (int i = 0; i < 10; i++) wcyc(1'b0, 1'b1, 9'(i * 7 + 1));
        wcyc(1'b1, 1'b1, '0);
        repeat (3) at_r();
        for (int i = 0; i < 3; i++) rcyc(1'b0, 1'b1, 1'b0);
        rcyc(1'b1, 1'b0, 1'b0);
        rcyc(1'b1, 1'b1, 1'b0);
        at_r();
        chk("R2 single enable pops nothing", int'(rd_data), 0);
        for (int i = 0; i < 12; i++) rcyc(1'b0, 1'b0, 1'b0);
        rcyc(1'b1, 1'b1, 1'b0);
        at_r();
        chk("R2 last word of burst", int'(rd_data), 9 * 7 + 1);

        // R7 R9: fill past capacity
        for (int i = 0; i < DEPTH + 4; i++) wcyc(1'b0, 1'b1, 9'(i));
        wcyc(1'b1, 1'b1, '0);
        at_w();
        chk("R7 full_n at capacity", int'(full_n), 0);
        chk("R8 almost_full_n at capacity", int'(almost_full_n), 0);
        repeat (3) at_r();
        chk("R8 almost_empty_n when full", int'(almost_empty_n), 1);

        // R9: drain with extra reads
        for (int i = 0; i < DEPTH + 6; i++) rcyc(1'b0, 1'b0, 1'b0);
        rcyc(1'b1, 1'b1, 1'b0);
        at_r();
        chk("R9 empty_n after over-read", int'(empty_n), 0);
        chk("R9 last kept word", int'(rd_data), DEPTH - 1);

        // offset-access personality
        do_reset(1'b0);
        wcyc(1'b0, 1'b0, 9'd3);
        wcyc(1'b0, 1'b0, 9'd5);
        wcyc(1'b1, 1'b0, '0);
        repeat (2) at_r();
        rcyc(1'b0, 1'b0, 1'b0);
        rcyc(1'b1, 1'b1, 1'b0);
        at_r();
        chk("R4 R5 empty threshold readback", int'(rd_data), 3);
        rcyc(1'b0, 1'b0, 1'b0);
        rcyc(1'b1, 1'b1, 1'b0);
        at_r();
        chk("R4 R5 full threshold readback", int'(rd_data), 5);
        wcyc(1'b0, 1'b0, 9'd4);
        wcyc(1'b1, 1'b0, '0);
        repeat (2) at_r();
        rcyc(1'b0, 1'b0, 1'b0);
        rcyc(1'b1, 1'b1, 1'b0);
        at_r();
        chk("R4 R5 wrapped readback", int'(rd_data), 4);
        chk("R5 queue untouched", int'(empty_n), 0);

        // R8 boundaries with thresholds 4 (empty side) and 5 (full side)
        for (int i = 0; i < 4; i++) wcyc(1'b0, 1'b1, 9'(200 + i));
        wcyc(1'b1, 1'b1, '0);
        repeat (3) at_r();
        chk("R8 level equals empty threshold", int'(almost_empty_n), 0);
        wcyc(1'b0, 1'b1, 9'd204);
        wcyc(1'b1, 1'b1, '0);
        repeat (3) at_r();
        chk("R8 level above empty threshold", int'(almost_empty_n), 1);
        for (int i = 5; i < 58; i++) wcyc(1'b0, 1'b1, 9'(200 + i));
        wcyc(1'b1, 1'b1, '0);
        at_w();
        chk("R8 room six", int'(almost_full_n), 1);
        wcyc(1'b0, 1'b1, 9'd258);
        wcyc(1'b1, 1'b1, '0);
        at_w();
        chk("R8 room five", int'(almost_full_n), 0);

        // R11: pop with the bus undriven, then drive again
        rcyc(1'b0, 1'b0, 1'b1);
        rcyc(1'b1, 1'b1, 1'b1);
        at_r();
        chk("R11 drive_en off", int'(drive_en), 0);
        chk("R11 bus zero", int'(rd_data), 0);
        rcyc(1'b1, 1'b1, 1'b0);
        at_r();
        chk("R11 drive_en on", int'(drive_en), 1);
        chk("R11 held word visible", int'(rd_data), 200);

        for (int i = 0; i < 70; i++) rcyc(1'b0, 1'b0, 1'b0);
        rcyc(1'b1, 1'b1, 1'b0);
        at_r();
        chk("R2 final drained word", int'(rd_data), 258);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule